// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block resolves branches for a 32-bit RISC pipeline. It handles three branch forms: an unconditional jump carrying a 24-bit word immediate, a conditional jump relative to the instruction address carrying a 14-bit word displacement, and a conditional jump through the count register. From the decoded fields, the current instruction address and the 32-bit condition register, it produces a taken flag and a target address in the same cycle. It also produces write-enables and new values for the count register and the link register, both of which it holds.

A 5-bit option field sets how a conditional branch decides. The field can decrement the count register and then test the new count for zero or non-zero. It can test one condition-register bit against a chosen polarity. It can do both, or neither. Register updates commit on the clock edge when the valid strobe is high. A separate load port writes the count register directly, which is how software places a loop count in it. A compatibility input selects whether a decrementing branch through the count register jumps to the count value before or after the decrement.

Top module: `branch_resolve_unit`

## Requirements
- R1: While rst_n is low, and after reset is released, the count register (ctr_o) and the link register (lr_o) read zero.
- R2: form_i = 0 (unconditional) is always taken. The immediate is sign-extended and shifted left by two. When abs_i = 1 the target is that value alone. When abs_i = 0 the target is pc_i plus that value.
- R3: form_i = 1 (conditional relative) targets pc_i plus the displacement, sign-extended and shifted left by two.
- R4: cbit_i = i tests bit cr_i[31-i], so index 0 is the most significant bit.
- R5: For form_i = 1 or 2, opt_i[2] = 0 requests a decrement: ctr_we_o is high when valid_i is high, ctr_next_o = ctr_o - 1 (modulo 2^32), and the register takes that value at the edge. With opt_i[2] = 1 the count register is unchanged.
- R6: When decrementing, opt_i[1] = 0 needs the new count to be non-zero in order to branch, and opt_i[1] = 1 needs it to be zero.
- R7: opt_i[4] = 0 needs the selected bit to equal opt_i[3] in order to branch. opt_i[4] = 1 ignores the bit. opt_i[0] never affects any output, and opt_i[1] has no effect when opt_i[2] = 1.
- R8: form_i = 2 targets the count value with its low two bits cleared. For a decrementing option, compat_i = 1 uses the value before the decrement and compat_i = 0 uses the value after it.
- R9: For form_i 0 to 2 with link_i = 1, lr_we_o = valid_i and lr_next_o = pc_i + 4. The link register takes that value at the edge.
- R10: With valid_i low, neither register changes, apart from a load under R11.
- R11: ctr_load_i = 1 writes ctr_load_val_i into the count register at the edge, whatever valid_i is, and takes priority over a branch decrement.
- R12: form_i = 3 is reserved. It is never taken, writes no register, and outputs pc_i + 4 as the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Branch instruction valid, commits updates |
| form_i | input | 2 | 0 unconditional, 1 conditional relative, 2 via count register, 3 reserved |
| imm_i | input | 24 | Word immediate of the unconditional form |
| disp_i | input | 14 | Word displacement of the conditional relative form |
| opt_i | input | 5 | Branch option field |
| cbit_i | input | 5 | Condition bit index |
| abs_i | input | 1 | Absolute target select for the unconditional form |
| link_i | input | 1 | Update link register |
| compat_i | input | 1 | Use pre-decrement count as the count-register target |
| pc_i | input | 32 | Current instruction address |
| cr_i | input | 32 | Condition register |
| ctr_load_i | input | 1 | Direct count register write |
| ctr_load_val_i | input | 32 | Value for the direct write |
| taken_o | output | 1 | Branch taken |
| target_o | output | 32 | Branch target address |
| ctr_we_o | output | 1 | Count register decrement write-enable |
| ctr_next_o | output | 32 | Decremented count value |
| lr_we_o | output | 1 | Link register write-enable |
| lr_next_o | output | 32 | Return address |
| ctr_o | output | 32 | Count register |
| lr_o | output | 32 | Link register |

## Verification
Several properties are checked on every clock cycle. An unconditional branch is always taken. The reserved form stays quiet. A count-register target is word aligned. An option field with both the decrement and the condition test disabled always branches. A committed decrement lowers the count by exactly one. A direct load overrides everything else. The link register captures the return address, and both registers hold while nothing commits. Other behaviour can only be shown by the bench's scenarios, which run against a behavioural model: the bit ordering of the condition index, the zero and non-zero count tests at the wrap boundary, the pre- and post-decrement target choice, and the insensitivity to the hint bit.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    FORM_IMM = 2'd0,
    FORM_REL = 2'd1,
    FORM_CTR = 2'd2,
    FORM_RSV = 2'd3
  } br_form_e;

  // decoded view of the option field (hint bit excluded)
  typedef struct packed {
    logic cond_ign;   // ignore condition bit
    logic cond_pol;   // required polarity of condition bit
    logic no_dec;     // skip the count decrement
    logic zero_tst;   // require new count == 0 (else != 0)
  } opt_dec_t;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int CBIT_W = $clog2(XLEN)
) (
  input  opt_dec_t          opt_i,
  input  logic [CBIT_W-1:0] cbit_i,
  input  logic [XLEN-1:0]   cr_i,
  input  logic [XLEN-1:0]   ctr_i,
  output logic              dec_o,
  output logic [XLEN-1:0]   ctr_dec_o,
  output logic              pass_o
);
  logic [XLEN-1:0] cr_msb0;
  logic            sel_bit;
  logic            cnt_ok;
  logic            cond_ok;

  // bit index counts from the most significant end
  for (genvar g = 0; g < XLEN; g++) begin : g_rev
    assign cr_msb0[g] = cr_i[XLEN-1-g];
  end

  always_comb begin
    sel_bit   = cr_msb0[cbit_i];
    dec_o     = ~opt_i.no_dec;
    ctr_dec_o = ctr_i - XLEN'(1);
    cnt_ok    = opt_i.no_dec | ((ctr_dec_o == '0) == opt_i.zero_tst);
    cond_ok   = opt_i.cond_ign | (sel_bit == opt_i.cond_pol);
    pass_o    = cnt_ok & cond_ok;
  end
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen
  import bru_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 24,
  parameter int DISP_W = 14
) (
  input  br_form_e          form_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              abs_i,
  input  logic              dec_i,
  input  logic              compat_i,
  input  logic [XLEN-1:0]   ctr_i,
  input  logic [XLEN-1:0]   ctr_dec_i,
  output logic [XLEN-1:0]   target_o
);
  localparam int IMM_PAD  = XLEN - IMM_W - 2;
  localparam int DISP_PAD = XLEN - DISP_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] ctr_src;

  always_comb begin
    imm_ext  = {{IMM_PAD{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    disp_ext = {{DISP_PAD{disp_i[DISP_W-1]}}, disp_i, 2'b00};
    ctr_src  = (dec_i && !compat_i) ? ctr_dec_i : ctr_i;
    unique case (form_i)
      FORM_IMM: target_o = abs_i ? imm_ext : pc_i + imm_ext;
      FORM_REL: target_o = pc_i + disp_ext;
      FORM_CTR: target_o = {ctr_src[XLEN-1:2], 2'b00};
      default:  target_o = pc_i + STEP;
    endcase
  end
endmodule

// File: rtl/bru_state_regs.sv
module bru_state_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_i,
  input  logic [XLEN-1:0] ld_val_i,
  input  logic            ctr_we_i,
  input  logic [XLEN-1:0] ctr_next_i,
  input  logic            lr_we_i,
  input  logic [XLEN-1:0] lr_next_i,
  output logic [XLEN-1:0] ctr_q,
  output logic [XLEN-1:0] lr_q
);
  logic [XLEN-1:0] ctr_d;
  logic [XLEN-1:0] lr_d;
  logic            ctr_en;

  always_comb begin
    ctr_en = ld_i | ctr_we_i;
    ctr_d  = ld_i ? ld_val_i : ctr_next_i;
    lr_d   = lr_next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      lr_q  <= '0;
    end else begin
      if (ctr_en)  ctr_q <= ctr_d;
      if (lr_we_i) lr_q  <= lr_d;
    end
  end

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> ctr_q == $past(ld_val_i));
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 24,
  parameter int DISP_W = 14,
  localparam int OPT_W  = 5,
  localparam int CBIT_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [1:0]        form_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [OPT_W-1:0]  opt_i,
  input  logic [CBIT_W-1:0] cbit_i,
  input  logic              abs_i,
  input  logic              link_i,
  input  logic              compat_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   cr_i,
  input  logic              ctr_load_i,
  input  logic [XLEN-1:0]   ctr_load_val_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic              ctr_we_o,
  output logic [XLEN-1:0]   ctr_next_o,
  output logic              lr_we_o,
  output logic [XLEN-1:0]   lr_next_o,
  output logic [XLEN-1:0]   ctr_o,
  output logic [XLEN-1:0]   lr_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  br_form_e        form;
  opt_dec_t        opt_dec;
  logic            unused_hint;
  logic            is_cond;
  logic            dec_req;
  logic            pass;
  logic [XLEN-1:0] ctr_dec;

  always_comb begin
    form        = br_form_e'(form_i);
    opt_dec     = '{cond_ign: opt_i[4], cond_pol: opt_i[3],
                    no_dec: opt_i[2], zero_tst: opt_i[1]};
    unused_hint = opt_i[0];
  end

  bru_cond_eval #(.XLEN(XLEN)) u_cond (
    .opt_i     (opt_dec),
    .cbit_i    (cbit_i),
    .cr_i      (cr_i),
    .ctr_i     (ctr_o),
    .dec_o     (dec_req),
    .ctr_dec_o (ctr_dec),
    .pass_o    (pass)
  );

  always_comb begin
    is_cond    = (form == FORM_REL) || (form == FORM_CTR);
    unique case (form)
      FORM_IMM:           taken_o = 1'b1;
      FORM_REL, FORM_CTR: taken_o = pass;
      default:            taken_o = 1'b0;
    endcase
    ctr_we_o   = valid_i & is_cond & dec_req;
    ctr_next_o = ctr_dec;
    lr_we_o    = valid_i & link_i & (form != FORM_RSV);
    lr_next_o  = pc_i + STEP;
  end

  bru_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .DISP_W(DISP_W)) u_tgt (
    .form_i    (form),
    .pc_i      (pc_i),
    .imm_i     (imm_i),
    .disp_i    (disp_i),
    .abs_i     (abs_i),
    .dec_i     (dec_req),
    .compat_i  (compat_i),
    .ctr_i     (ctr_o),
    .ctr_dec_i (ctr_dec),
    .target_o  (target_o)
  );

  bru_state_regs #(.XLEN(XLEN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_i       (ctr_load_i),
    .ld_val_i   (ctr_load_val_i),
    .ctr_we_i   (ctr_we_o),
    .ctr_next_i (ctr_next_o),
    .lr_we_i    (lr_we_o),
    .lr_next_i  (lr_next_o),
    .ctr_q      (ctr_o),
    .lr_q       (lr_o)
  );

  // R2
  uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    form_i == 2'd0 |-> taken_o);

  // R12
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    form_i == 2'd3 |-> !taken_o && !ctr_we_o && !lr_we_o && target_o == pc_i + STEP);

  // R8
  ctr_tgt_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    form_i == 2'd2 |-> target_o[1:0] == 2'b00);

  // R7
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == 2'd1 || form_i == 2'd2) && opt_i[4] && opt_i[2] |-> taken_o);

  // R5
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_we_o && !ctr_load_i |=> ctr_o == $past(ctr_o) - XLEN'(1));

  // R9
  lr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we_o |=> lr_o == $past(pc_i) + STEP);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i && !ctr_load_i |=> $stable(ctr_o) && $stable(lr_o));
endmodule

// File: tb/sim_branch_resolve_unit.sv
`timescale 1ns/1ps
module sim_branch_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, abs_i, link_i, compat_i, ctr_load_i;
  logic [1:0]  form_i;
  logic [23:0] imm_i;
  logic [13:0] disp_i;
  logic [4:0]  opt_i, cbit_i;
  logic [31:0] pc_i, cr_i, ctr_load_val_i;
  logic        taken_o, ctr_we_o, lr_we_o;
  logic [31:0] target_o, ctr_next_o, lr_next_o, ctr_o, lr_o;

  int checks = 0;
  int errors = 0;
  string scen = "RND";
  logic [31:0] m_ctr, m_lr;

  always #4 clk = ~clk;

  branch_resolve_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .form_i(form_i),
    .imm_i(imm_i), .disp_i(disp_i), .opt_i(opt_i), .cbit_i(cbit_i),
    .abs_i(abs_i), .link_i(link_i), .compat_i(compat_i), .pc_i(pc_i),
    .cr_i(cr_i), .ctr_load_i(ctr_load_i), .ctr_load_val_i(ctr_load_val_i),
    .taken_o(taken_o), .target_o(target_o), .ctr_we_o(ctr_we_o),
    .ctr_next_o(ctr_next_o), .lr_we_o(lr_we_o), .lr_next_o(lr_next_o),
    .ctr_o(ctr_o), .lr_o(lr_o)
  );

  task automatic chk(string fld, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", scen, fld, act, exp);
    end
  endtask

  // behavioural reference: decision for the conditional forms
  function automatic bit ref_dec(input logic [4:0] o);
    casez (o)
      5'b0000?, 5'b0001?, 5'b0100?, 5'b0101?, 5'b1?00?, 5'b1?01?: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_pass(input logic [4:0] o, input logic [31:0] c,
                                  input logic [31:0] cr, input int idx);
    logic [31:0] n;
    bit cb;
    n  = c - 1;
    cb = cr[31 - idx];
    casez (o)
      5'b0000?: return (n != 0) && !cb;
      5'b0001?: return (n == 0) && !cb;
      5'b001??: return !cb;
      5'b0100?: return (n != 0) && cb;
      5'b0101?: return (n == 0) && cb;
      5'b011??: return cb;
      5'b1?00?: return n != 0;
      5'b1?01?: return n == 0;
      default:  return 1'b1;
    endcase
  endfunction

  task automatic compare();
    bit e_taken, d;
    logic [31:0] e_tgt, off;
    d = ref_dec(opt_i) && (form_i == 1 || form_i == 2);
    case (form_i)
      2'd0: begin
        e_taken = 1;
        off = 32'($signed(imm_i)) * 4;
        e_tgt = abs_i ? off : pc_i + off;
      end
      2'd1: begin
        e_taken = ref_pass(opt_i, m_ctr, cr_i, int'(cbit_i));
        e_tgt = pc_i + 32'($signed(disp_i)) * 4;
      end
      2'd2: begin
        e_taken = ref_pass(opt_i, m_ctr, cr_i, int'(cbit_i));
        e_tgt = (d && !compat_i) ? m_ctr - 1 : m_ctr;
        e_tgt[1:0] = 2'b00;
      end
      default: begin
        e_taken = 0;
        e_tgt = pc_i + 4;
      end
    endcase
    chk(form_i == 0 ? "R2 taken" : (form_i == 3 ? "R12 taken" : "R7 taken"),
        32'(taken_o), 32'(e_taken));
    chk(form_i == 0 ? "R2 target" : form_i == 1 ? "R3 target" :
        form_i == 2 ? "R8 target" : "R12 target", target_o, e_tgt);
    chk("R5 ctr_we", 32'(ctr_we_o), 32'(valid_i && d));
    if (d) chk("R5 ctr_next", ctr_next_o, m_ctr - 1);
    chk("R9 lr_we", 32'(lr_we_o), 32'(valid_i && link_i && form_i != 3));
    chk("R9 lr_next", lr_next_o, pc_i + 4);
    chk("R5 ctr_o", ctr_o, m_ctr);
    chk("R9 lr_o", lr_o, m_lr);
  endtask

  task automatic tick();
    bit d;
    @(negedge clk);
    compare();
    @(posedge clk);
    d = ref_dec(opt_i) && (form_i == 1 || form_i == 2);
    if (ctr_load_i) m_ctr = ctr_load_val_i;
    else if (valid_i && d) m_ctr = m_ctr - 1;
    if (valid_i && link_i && form_i != 3) m_lr = pc_i + 4;
    #1;
  endtask

  task automatic quiet();
    valid_i = 0; ctr_load_i = 0; link_i = 0; abs_i = 0; compat_i = 0;
    form_i = 0; imm_i = 0; disp_i = 0; opt_i = 5'b10100; cbit_i = 0;
    pc_i = 32'h1000; cr_i = 0; ctr_load_val_i = 0;
  endtask

  task automatic load(logic [31:0] v);
    quiet(); ctr_load_i = 1; ctr_load_val_i = v; form_i = 3; tick();
    ctr_load_i = 0;
  endtask

  initial begin
    quiet();
    m_ctr = 0; m_lr = 0;
    rst_n = 0;
    #2;
    pc_i = 32'h1234; valid_i = 1; link_i = 1; ctr_load_i = 1; ctr_load_val_i = 32'h55;
    @(negedge clk); @(negedge clk);
    scen = "R1";
    chk("R1 ctr_o in reset", ctr_o, 32'h0);
    chk("R1 lr_o in reset", lr_o, 32'h0);
    quiet();
    rst_n = 1;
    @(posedge clk); #1;
    tick();

    // R2 both addressing kinds, negative immediate
    scen = "R2";
    quiet(); form_i = 0; imm_i = 24'hFFFFFE; pc_i = 32'h0000_2000; tick();
    abs_i = 1; tick();
    abs_i = 0; imm_i = 24'h000010; link_i = 1; valid_i = 1; tick();

    // R3 negative and positive displacement
    scen = "R3";
    quiet(); form_i = 1; opt_i = 5'b10100; disp_i = 14'h3FFF; pc_i = 32'h100; tick();
    disp_i = 14'h1FFF; tick();

    // R4 sweep the condition index over a single set bit
    scen = "R4";
    for (int i = 0; i < 32; i++) begin
      quiet(); form_i = 1; opt_i = 5'b01100; cbit_i = 5'(i); cr_i = 32'h8000_0000; tick();
      quiet(); form_i = 1; opt_i = 5'b00100; cbit_i = 5'(i); cr_i = 32'h0000_0001; tick();
    end

    // R6 zero / non-zero test around the boundary
    scen = "R6";
    load(32'd1);
    quiet(); form_i = 1; opt_i = 5'b10010; valid_i = 1; tick(); // new 0 -> taken
    quiet(); form_i = 1; opt_i = 5'b10010; tick();              // new FFFFFFFF
    quiet(); form_i = 1; opt_i = 5'b10000; tick();
    load(32'd2);
    quiet(); form_i = 1; opt_i = 5'b10000; valid_i = 1; tick();
    quiet(); form_i = 1; opt_i = 5'b10000; tick();

    // R7 hint bit and ignored zero-test bit
    scen = "R7";
    for (int o = 0; o < 32; o++) begin
      quiet(); form_i = 1; opt_i = 5'(o); cr_i = 32'h4000_0000; cbit_i = 1; tick();
    end

    // R8 count-register target, both modes
    scen = "R8";
    load(32'h0000_1003);
    quiet(); form_i = 2; opt_i = 5'b10000; compat_i = 1; tick();
    compat_i = 0; tick();
    opt_i = 5'b10100; tick();
    load(32'h0000_2000);
    quiet(); form_i = 2; opt_i = 5'b10000; compat_i = 0; valid_i = 1; tick();

    // R10 nothing commits without valid
    scen = "R10";
    quiet(); form_i = 1; opt_i = 5'b10000; link_i = 1; pc_i = 32'hABC0; tick();
    chk("R10 ctr held", ctr_o, 32'h0000_1FFF);
    chk("R10 lr held", lr_o, m_lr);

    // R11 load beats simultaneous decrement
    scen = "R11";
    quiet(); form_i = 1; opt_i = 5'b10000; valid_i = 1; ctr_load_i = 1;
    ctr_load_val_i = 32'h77; tick();
    quiet(); tick();
    chk("R11 load priority", ctr_o, 32'h77);

    // R12 reserved form
    scen = "R12";
    quiet(); form_i = 3; valid_i = 1; link_i = 1; opt_i = 5'b00000; tick();

    // random traffic against the model
    scen = "RND";
    for (int n = 0; n < 4000; n++) begin
      valid_i  = $urandom_range(0, 3) != 0;
      form_i   = 2'($urandom);
      imm_i    = 24'($urandom);
      disp_i   = 14'($urandom);
      opt_i    = 5'($urandom);
      cbit_i   = 5'($urandom);
      abs_i    = 1'($urandom);
      link_i   = 1'($urandom);
      compat_i = 1'($urandom);
      pc_i     = $urandom & 32'hFFFF_FFFC;
      cr_i     = $urandom;
      ctr_load_i = $urandom_range(0, 7) == 0;
      ctr_load_val_i = $urandom_range(0, 1) ? 32'($urandom_range(0, 3)) : $urandom;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule